// File: doc/BRIEF.md
# Parity-Guided Single-Bit Corrector Using Set-Membership Queries

When an element read from a parity-protected store fails its parity check, this block tries to repair it without any ECC check bits. It builds a list of candidate values: the word exactly as read (the case where only the parity bit was hit), then the word with bit 0 inverted, then bit 1 inverted, and so on up to the top bit. Each candidate is sent in turn to an existing counting membership filter through a query port. The block counts how many candidates the filter reports as members.

If exactly one candidate is a member, that candidate is returned as the corrected element. If two or more are members, false positives make the answer unsafe, so the block reports that a slower, more thorough procedure must take over. It stops querying as soon as the second hit arrives. If no candidate is a member, it reports the error as uncorrectable. The default element width is 64 bits, enough for a pair of IPv4 addresses.

Internally a four-state sequencer walks the states `S_IDLE`, `S_ASK`, `S_WAIT` and `S_DONE`. The transitions are: `S_IDLE`→`S_ASK` on a start pulse; `S_ASK`→`S_WAIT` when the query is accepted; `S_WAIT`→`S_ASK` on a response while candidates remain and no second hit has been seen; `S_WAIT`→`S_DONE` on the response to the last candidate or on a second hit; and `S_DONE`→`S_IDLE` unconditionally after the one result cycle.

Top module: `bf_flip_corrector`

## Requirements
- R1: A correction attempt starts only on a cycle where `err_start_i` is high while the block is idle. `err_data_i` is captured on that cycle. A start pulse during an attempt is ignored and does not change its queries or result.
- R2: Query number k (counting from 0) carries the captured word for k = 0, and the captured word with bit k-1 inverted for k ≥ 1. Queries are issued in increasing k.
- R3: `qry_valid_o` stays high with stable `qry_data_o` until `qry_ready_i` is seen high. A query is accepted on a clock edge where both are high. The next query is not raised until `qry_rsp_valid_i` has returned for the previous one. A response is expected at least one cycle after acceptance.
- R4: With fewer than two hits, exactly DATA_W+1 queries are issued per attempt.
- R5: When a second hit is returned, no further query is issued in that attempt.
- R6: Exactly one hit gives status 2'b01, and `res_data_o` equals the candidate that hit.
- R7: Two or more hits give status 2'b10 (escalate), and `res_data_o` equals the word as captured.
- R8: Zero hits give status 2'b11 (uncorrectable), and `res_data_o` equals the word as captured.
- R9: `res_valid_o` is high for exactly one cycle per attempt. While it is low, `res_status_o` is 2'b00.
- R10: `res_parity_o` equals the XOR of all bits of `res_data_o` (even parity).
- R11: During and right after reset, `qry_valid_o` and `res_valid_o` are low and `res_status_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_start_i | input | 1 | Parity mismatch seen on an element read |
| err_data_i | input | DATA_W | Element word as read |
| qry_valid_o | output | 1 | Membership query request |
| qry_data_o | output | DATA_W | Candidate being queried |
| qry_ready_i | input | 1 | Filter accepts the query |
| qry_rsp_valid_i | input | 1 | Filter answer present |
| qry_rsp_hit_i | input | 1 | Filter reports the candidate as a member |
| res_valid_o | output | 1 | Result present for one cycle |
| res_status_o | output | 2 | 00 idle, 01 corrected, 10 escalate, 11 uncorrectable |
| res_data_o | output | DATA_W | Corrected or as-read word |
| res_parity_o | output | 1 | Even parity of res_data_o |

## Verification
The checker watches every cycle for the following:
- the result pulse lasting a single cycle;
- a zero status outside that pulse;
- a nonzero status inside it;
- the output parity matching the output word;
- a pending query holding its data until it is accepted.

Only the bench scenarios can show the rest:
- the candidate order;
- the full count of DATA_W+1 queries;
- the early stop on a second hit;
- the choice of corrected word against the filter's membership pattern, including a hit on the very first and on the very last candidate;
- ignoring a start pulse mid-attempt;
- correct sequencing while the filter stalls acceptance.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
    typedef enum logic [1:0] {
        FIX_NONE  = 2'b00,
        FIX_OK    = 2'b01,
        FIX_AMBIG = 2'b10,
        FIX_LOST  = 2'b11
    } fix_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ASK,
        S_WAIT,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/bfc_cand_gen.sv
module bfc_cand_gen #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] cand_o
);
    logic [DATA_W-1:0] flip_mask;

    // index 0 leaves the word unchanged; index i+1 inverts bit i
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign flip_mask[i] = (idx_i == IDX_W'(i + 1));
    end

    assign cand_o = base_i ^ flip_mask;
endmodule

// File: rtl/bfc_hit_tally.sv
module bfc_hit_tally #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              hit_take_i,
    input  logic [DATA_W-1:0] cand_i,
    output logic [1:0]        hits_o,
    output logic [DATA_W-1:0] first_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hits_o  <= 2'd0;
            first_o <= '0;
        end else if (clear_i) begin
            hits_o  <= 2'd0;
            first_o <= '0;
        end else if (hit_take_i) begin
            if (hits_o == 2'd0) first_o <= cand_i;
            if (hits_o != 2'd2) hits_o <= hits_o + 2'd1;
        end
    end
endmodule

// File: rtl/bfc_seq_fsm.sv
module bfc_seq_fsm
    import bfc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             qry_ready_i,
    input  logic             rsp_valid_i,
    input  logic             rsp_hit_i,
    input  logic [1:0]       hits_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             clear_o,
    output logic             qry_valid_o,
    output logic             hit_take_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);

    seq_state_e state_q, state_d;
    logic       idx_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_o   <= '0;
        end else begin
            state_q <= state_d;
            if (clear_o)      idx_o <= '0;
            else if (idx_inc) idx_o <= idx_o + 1'b1;
        end
    end

    always_comb begin
        state_d     = state_q;
        clear_o     = 1'b0;
        qry_valid_o = 1'b0;
        hit_take_o  = 1'b0;
        done_o      = 1'b0;
        idx_inc     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    clear_o = 1'b1;
                    state_d = S_ASK;
                end
            end
            S_ASK: begin
                qry_valid_o = 1'b1;
                if (qry_ready_i) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (rsp_valid_i) begin
                    hit_take_o = rsp_hit_i;
                    if (rsp_hit_i && hits_i == 2'd1) begin
                        state_d = S_DONE;
                    end else if (idx_o == LAST_IDX) begin
                        state_d = S_DONE;
                    end else begin
                        idx_inc = 1'b1;
                        state_d = S_ASK;
                    end
                end
            end
            S_DONE: begin
                done_o  = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end
endmodule

// File: rtl/bf_flip_corrector.sv
module bf_flip_corrector
    import bfc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_start_i,
    input  logic [DATA_W-1:0] err_data_i,
    output logic              qry_valid_o,
    output logic [DATA_W-1:0] qry_data_o,
    input  logic              qry_ready_i,
    input  logic              qry_rsp_valid_i,
    input  logic              qry_rsp_hit_i,
    output logic              res_valid_o,
    output logic [1:0]        res_status_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic              res_parity_o
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] first_hit;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        hits;
    logic              clear, hit_take, done;
    fix_status_e       status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     base_q <= '0;
        else if (clear) base_q <= err_data_i;
    end

    bfc_seq_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (err_start_i),
        .qry_ready_i (qry_ready_i),
        .rsp_valid_i (qry_rsp_valid_i),
        .rsp_hit_i   (qry_rsp_hit_i),
        .hits_i      (hits),
        .idx_o       (idx),
        .clear_o     (clear),
        .qry_valid_o (qry_valid_o),
        .hit_take_o  (hit_take),
        .done_o      (done)
    );

    bfc_cand_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cand (
        .base_i (base_q),
        .idx_i  (idx),
        .cand_o (qry_data_o)
    );

    bfc_hit_tally #(.DATA_W(DATA_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .hit_take_i (hit_take),
        .cand_i     (qry_data_o),
        .hits_o     (hits),
        .first_o    (first_hit)
    );

    always_comb begin
        status     = FIX_NONE;
        res_data_o = '0;
        if (done) begin
            unique case (hits)
                2'd0:    begin status = FIX_LOST;  res_data_o = base_q;    end
                2'd1:    begin status = FIX_OK;    res_data_o = first_hit; end
                default: begin status = FIX_AMBIG; res_data_o = base_q;    end
            endcase
        end
    end

    assign res_valid_o  = done;
    assign res_status_o = status;
    assign res_parity_o = ^res_data_o;
endmodule

// File: rtl/bfc_corrector_chk.sv
module bfc_corrector_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              qry_valid_o,
    input logic [DATA_W-1:0] qry_data_o,
    input logic              qry_ready_i,
    input logic              res_valid_o,
    input logic [1:0]        res_status_o,
    input logic [DATA_W-1:0] res_data_o,
    input logic              res_parity_o
);
    AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o); // R9
    AST_IDLE_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> res_status_o == 2'b00); // R9
    AST_RES_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> res_status_o != 2'b00); // R6
    AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> res_parity_o == ^res_data_o); // R10
    AST_QRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid_o && !qry_ready_i) |=> (qry_valid_o && $stable(qry_data_o))); // R3
    AST_NO_QRY_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !qry_valid_o); // R5
endmodule

bind bf_flip_corrector bfc_corrector_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .qry_valid_o  (qry_valid_o),
    .qry_data_o   (qry_data_o),
    .qry_ready_i  (qry_ready_i),
    .res_valid_o  (res_valid_o),
    .res_status_o (res_status_o),
    .res_data_o   (res_data_o),
    .res_parity_o (res_parity_o)
);

// File: tb/bf_flip_corrector_test.sv
`timescale 1ns/1ps
module bf_flip_corrector_test;
    localparam int W  = 64;
    localparam int NV = 7;

    localparam logic [W-1:0] X    = 64'h0A00_0001_C0A8_0102;
    localparam logic [W-1:0] XB5  = 64'h0A00_0001_C0A8_0122;

    // vector table: as-read word, members A/B with enables, expected status, data, query count
    localparam logic [W-1:0] V_RD [NV] = '{XB5, X, 64'h8A00_0001_C0A8_0102,
        64'h0A00_0001_C0A8_0103, XB5, XB5, XB5};
    localparam logic [W-1:0] V_MA [NV] = '{X, X, X, X, X, 64'h1234_5678_9ABC_DEF0, X};
    localparam logic [W-1:0] V_MB [NV] = '{64'h0, 64'h0, 64'h0, 64'h0,
        64'h0A00_0001_C0A8_0322, 64'h0, XB5};
    localparam logic V_EA [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic V_EB [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [1:0] V_ST [NV] = '{2'b01, 2'b01, 2'b01, 2'b01, 2'b10, 2'b11, 2'b10};
    localparam logic [W-1:0] V_DT [NV] = '{X, X, X, X, XB5, XB5, XB5};
    localparam int V_NQ [NV] = '{65, 65, 65, 65, 11, 65, 7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_start_i = 1'b0;
    logic [W-1:0] err_data_i = '0;
    logic qry_valid_o;
    logic [W-1:0] qry_data_o;
    logic qry_ready_i = 1'b0;
    logic qry_rsp_valid_i = 1'b0;
    logic qry_rsp_hit_i = 1'b0;
    logic res_valid_o;
    logic [1:0] res_status_o;
    logic [W-1:0] res_data_o;
    logic res_parity_o;

    always #2.5 clk = ~clk;

    bf_flip_corrector #(.DATA_W(W)) uut (.*);

    int checks = 0;
    int errors = 0;
    logic [W-1:0] cur_rd, mem_a, mem_b;
    logic en_a = 1'b0, en_b = 1'b0, stall = 1'b0, pend = 1'b0;
    logic [W-1:0] pend_q;
    int nq = 0, order_err = 0, nres = 0, cyc = 0;
    logic [1:0] got_st;
    logic [W-1:0] got_dt;
    logic got_par;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // filter model and monitor
    always @(negedge clk) begin
        cyc++;
        qry_rsp_valid_i = 1'b0;
        qry_rsp_hit_i   = 1'b0;
        if (pend) begin
            qry_rsp_valid_i = 1'b1;
            qry_rsp_hit_i   = (en_a && pend_q == mem_a) || (en_b && pend_q == mem_b);
            pend = 1'b0;
        end
        qry_ready_i = stall ? cyc[0] : 1'b1;
        if (rst_n && qry_valid_o && qry_ready_i) begin
            if (qry_data_o !== (cur_rd ^ ((nq == 0) ? '0 : (64'b1 << (nq - 1))))) order_err++;
            nq++;
            pend_q = qry_data_o;
            pend = 1'b1;
        end
        if (rst_n && res_valid_o) begin
            nres++;
            got_st  = res_status_o;
            got_dt  = res_data_o;
            got_par = res_parity_o;
        end
    end

    task automatic run_case(input logic [W-1:0] rd, input logic [W-1:0] a, input logic ea,
                            input logic [W-1:0] b, input logic eb, input logic [1:0] est,
                            input logic [W-1:0] edt, input int enq, input bit inject,
                            input string tag);
        cur_rd = rd; mem_a = a; mem_b = b; en_a = ea; en_b = eb;
        nq = 0; order_err = 0; nres = 0;
        @(negedge clk); err_start_i = 1'b1; err_data_i = rd;
        @(negedge clk); err_start_i = 1'b0; err_data_i = '0;
        for (int t = 0; t < 3000 && nres == 0; t++) begin
            @(posedge clk); #1;
            err_start_i = (inject && t == 20);
            err_data_i  = (inject && t == 20) ? ~rd : '0;
        end
        err_start_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(nres == 1, {tag, " R9 one result pulse"}, nres, 1);
        chk(got_st == est, {tag, est == 2'b01 ? " R6" : est == 2'b10 ? " R7" : " R8", " status"}, got_st, est);
        chk(got_dt == edt, {tag, est == 2'b01 ? " R6" : est == 2'b10 ? " R7" : " R8", " data"}, got_dt, edt);
        chk(got_par == ^edt, {tag, " R10 parity"}, got_par, ^edt);
        chk(nq == enq, {tag, est == 2'b10 ? " R5 early stop" : " R4 full sweep", " query count"}, nq, enq);
        chk(order_err == 0, {tag, " R2 candidate order"}, order_err, 0);
        chk(res_status_o == 2'b00 && !res_valid_o, {tag, " R9 idle status"}, res_status_o, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cur_rd = '0; mem_a = '0; mem_b = '0; pend_q = '0;
        got_st = '0; got_dt = '0; got_par = 1'b0;
        repeat (3) @(negedge clk);
        chk(!qry_valid_o && !res_valid_o && res_status_o == 2'b00, "R11 reset state", {qry_valid_o, res_valid_o, res_status_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!qry_valid_o && !res_valid_o && res_status_o == 2'b00, "R11 after reset", {qry_valid_o, res_valid_o, res_status_o}, 0);

        for (int v = 0; v < NV; v++)
            run_case(V_RD[v], V_MA[v], V_EA[v], V_MB[v], V_EB[v], V_ST[v], V_DT[v], V_NQ[v], 1'b0, $sformatf("vec%0d", v));

        // R3: filter stalls acceptance on alternate cycles
        stall = 1'b1;
        run_case(XB5, X, 1'b1, '0, 1'b0, 2'b01, X, 65, 1'b0, "R3 stalled ready");
        run_case(XB5, X, 1'b1, 64'h0A00_0001_C0A8_0322, 1'b1, 2'b10, XB5, 11, 1'b0, "R3 stalled ambiguous");
        stall = 1'b0;

        // R1: start pulse during an attempt is ignored
        run_case(64'h0A00_0001_C0A8_0102 ^ (64'b1 << 40), X, 1'b1, '0, 1'b0, 2'b01, X, 65, 1'b1, "R1 busy start");
        chk(!qry_valid_o, "R1 no attempt from ignored start", qry_valid_o, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule